// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block sits between a two-wire serial bus and the storage of a byte-organised memory. It samples the bus clock and data lines on a fast system clock and recognises start and stop conditions. It collects bytes most significant bit first, acknowledges the ones addressed to it and shifts read data back out. The open-drain data line is driven through a single pull-low enable.

A transfer opens with a select byte. It carries a fixed four-bit tag, three select bits and a direction bit. A parameter sets how many of the select bits are compared with strap inputs. The select bits that are not compared become the top bits of the word address. The block keeps the current address itself. It sends address-load, byte-write and byte-read requests to a memory-side unit over a valid/acknowledge handshake. A busy input from that unit suppresses the acknowledge while an internal write is in progress, so the bus master can poll for completion.

Top module: `tws_slave`

## Requirements
- R1: A falling data line while the clock is high starts select-byte reception from any state. A rising data line while the clock is high returns the block to idle, and bytes sent after that without a new start are not acknowledged.
- R2: A select byte whose bits [7:4] are 1010 and whose compared select bits match the straps is acknowledged: sda_oe is 1 through the ninth clock. Any other select byte is not acknowledged, and the bus is ignored until the next start.
- R3: With SEL_CMP compared bits, select bits [3:1] are compared from bit 3 downward against strap[2] downward. The remaining lower select bits of a write select byte become word-address bits [ADDR_W-1:8].
- R4: In a write, the word-address byte and every data byte are acknowledged. The word address produces a load request (req_kind 0) carrying the full address. Each data byte produces a write request (req_kind 1) with the current address and the byte.
- R5: After each written byte, only the low PAGE_W address bits advance, wrapping inside the page. The upper bits stay unchanged.
- R6: A read issues a read request (req_kind 2) at the current address and shifts the returned byte out MSB first. Each delivered byte advances the address by one across the whole space, wrapping from the top address to 0.
- R7: A low data line on the ninth clock of a read byte makes the block send the next byte. A high one makes it release the line and issue no further read request.
- R8: A repeated start after a write's word address, with no data byte, keeps that address for the following read.
- R9: While wr_busy is 1, a matching select byte is not acknowledged and no request is issued.
- R10: A stop inside a byte discards the partial byte with no request and leaves memory unchanged. A start inside a byte restarts select reception, and a complete select byte that follows is acknowledged.
- R11: sda_oe changes only while the bus clock is low.
- R12: After reset, sda_oe and req_valid are 0 and the current address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Select-bit straps, compared from bit 2 downward |
| wr_busy | input | 1 | Memory side is still completing a write |
| req_valid | output | 1 | Request to the memory side, held until req_ack |
| req_kind | output | 2 | 0 load address, 1 write byte, 2 read byte |
| req_addr | output | ADDR_W | Word address of the request |
| req_wdata | output | 8 | Byte to write |
| req_ack | input | 1 | One-cycle acknowledge of the pending request |
| rd_data | input | 8 | Read byte, valid with req_ack of a read |

## Verification
The assertions assume a legal bus. No master starts or stops while the slave holds the data line low. The memory side acknowledges each request before the next one and well within one bus-clock high phase, so read data is ready before the first bit must be driven. The bench keeps within this. Its master holds each clock phase for many system clocks and moves the data line only a few cycles after the clock has fallen. It never frames a condition while the slave drives. Its memory model answers every request after one cycle.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } st_t;

    typedef enum logic [1:0] {
        REQ_LOAD  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_READ  = 2'd2
    } req_kind_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [3:0] SEL_TAG = 4'b1010;

    // tag check plus the top ncmp select bits against the straps
    function automatic logic sel_match(input logic [7:0] b,
                                       input logic [2:0] strap,
                                       input int ncmp);
        logic ok;
        ok = (b[7:4] == SEL_TAG);
        for (int i = 0; i < 3; i++) begin
            if (i < ncmp && b[3-i] != strap[2-i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/tws_edge.sv
module tws_edge
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_ff, sda_ff;
    logic          scl_q, sda_q;

    generate
        for (genvar g = 0; g <= LAST; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_ff[g] <= scl_i;
                    sda_ff[g] <= sda_i;
                end else begin
                    scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
                    sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ff[LAST];
            sda_q <= sda_ff[LAST];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[LAST];
        ev.sda      = sda_ff[LAST];
        ev.scl_rise = scl_ff[LAST] & ~scl_q;
        ev.scl_fall = ~scl_ff[LAST] & scl_q;
        ev.start    = scl_ff[LAST] & scl_q & sda_q & ~sda_ff[LAST];
        ev.stop     = scl_ff[LAST] & scl_q & ~sda_q & sda_ff[LAST];
    end

endmodule

// File: rtl/tws_ptr.sv
module tws_ptr #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] ptr
);
    logic [PAGE_W-1:0] low_next;

    assign low_next = ptr[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc_page) begin
            ptr <= {ptr[ADDR_W-1:PAGE_W], low_next};
        end else if (inc_full) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int SEL_CMP     = 1,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int HI_W       = 3 - SEL_CMP,
    localparam int ADDR_W     = 8 + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap,
    input  logic              wr_busy,
    output logic              req_valid,
    output logic [1:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_wdata,
    input  logic              req_ack,
    input  logic [7:0]        rd_data
);
    localparam int HI_KEEP = (HI_W > 0) ? HI_W : 1;

    bus_ev_t            ev;
    st_t                st, nxt;
    req_kind_t          kind;
    logic [2:0]         cnt;
    logic [7:0]         sh, rd_sh, byte_in;
    logic [HI_KEEP-1:0] sel_hi;
    logic               drv, more;
    logic               last_bit, sel_ok;
    logic               ld, inc_page, inc_full;
    logic [ADDR_W-1:0]  ld_val, ptr;
    logic               scl_sync, start_ev;

    tws_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign ld_val = {sel_hi, byte_in};
        end else begin : g_nohi
            assign ld_val = byte_in;
        end
    endgenerate

    always_comb begin
        byte_in  = {sh[6:0], ev.sda};
        last_bit = ev.scl_rise && (cnt == 3'd7);
        sel_ok   = sel_match(byte_in, strap, SEL_CMP) && !wr_busy;
        ld       = (st == ST_WADDR) && last_bit;
        inc_page = (st == ST_WDATA) && last_bit;
        inc_full = req_valid && req_ack && (kind == REQ_READ);
        scl_sync = ev.scl;
        start_ev = ev.start;
    end

    tws_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst(rst), .load(ld), .load_val(ld_val),
        .inc_page(inc_page), .inc_full(inc_full), .ptr(ptr)
    );

    assign req_kind = kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            nxt       <= ST_IDLE;
            kind      <= REQ_LOAD;
            cnt       <= '0;
            sh        <= '0;
            rd_sh     <= '0;
            sel_hi    <= '0;
            drv       <= 1'b0;
            more      <= 1'b0;
            sda_oe    <= 1'b0;
            req_valid <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            if (req_valid && req_ack) begin
                req_valid <= 1'b0;
                if (kind == REQ_READ) rd_sh <= rd_data;
            end
            if (ev.start) begin
                st     <= ST_SEL;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_SEL: if (ev.scl_rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            if (sel_ok) begin
                                st  <= ST_ACK;
                                drv <= 1'b0;
                                if (byte_in[0]) begin
                                    nxt       <= ST_RDATA;
                                    req_valid <= 1'b1;
                                    kind      <= REQ_READ;
                                    req_addr  <= ptr;
                                end else begin
                                    nxt    <= ST_WADDR;
                                    sel_hi <= byte_in[HI_KEEP:1];
                                end
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_WADDR: if (ev.scl_rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            st        <= ST_ACK;
                            drv       <= 1'b0;
                            nxt       <= ST_WDATA;
                            req_valid <= 1'b1;
                            kind      <= REQ_LOAD;
                            req_addr  <= ld_val;
                        end
                    end
                    ST_WDATA: if (ev.scl_rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            st        <= ST_ACK;
                            drv       <= 1'b0;
                            nxt       <= ST_WDATA;
                            req_valid <= 1'b1;
                            kind      <= REQ_WRITE;
                            req_addr  <= ptr;
                            req_wdata <= byte_in;
                        end
                    end
                    ST_ACK: if (ev.scl_fall) begin
                        if (!drv) begin
                            drv    <= 1'b1;
                            sda_oe <= 1'b1;
                        end else begin
                            st     <= nxt;
                            cnt    <= '0;
                            sda_oe <= (nxt == ST_RDATA) ? ~rd_sh[7] : 1'b0;
                        end
                    end
                    ST_RDATA: if (ev.scl_fall) begin
                        if (cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            st     <= ST_RACK;
                        end else begin
                            cnt    <= cnt + 3'd1;
                            rd_sh  <= {rd_sh[6:0], 1'b0};
                            sda_oe <= ~rd_sh[6];
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            more <= !ev.sda;
                            if (!ev.sda) begin
                                req_valid <= 1'b1;
                                kind      <= REQ_READ;
                                req_addr  <= ptr;
                            end
                        end else if (ev.scl_fall) begin
                            if (more) begin
                                st     <= ST_RDATA;
                                cnt    <= '0;
                                sda_oe <= ~rd_sh[7];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk
    import tws_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              scl_sync,
    input logic              start_ev,
    input st_t               st,
    input logic              req_valid,
    input logic              req_ack,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr
);
    // R11: the pull-low enable only turns on during the clock low phase
    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_sync);

    // R4: a pending request keeps its kind and address until acknowledged
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_kind)));

    // R1: a start always leaves the data line released
    a_r1_start_release: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !sda_oe);

    // R2: the line is pulled only in an acknowledge or read-data phase
    a_r2_oe_phase: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (st == ST_ACK || st == ST_RDATA));

endmodule

bind tws_slave tws_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_sync(scl_sync),
    .start_ev(start_ev), .st(st), .req_valid(req_valid), .req_ack(req_ack),
    .req_kind(req_kind), .req_addr(req_addr)
);

// File: tb/tb_tws_slave.sv
module tb_tws_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q    = 12;
    localparam int HOLD = 4;
    localparam int AW   = 10;

    // {expected ack, select byte}; straps 3'b101, one compared bit (R2, R3)
    localparam logic [8:0] VEC [8] = '{
        {1'b1, 8'hA8}, {1'b1, 8'hAE}, {1'b0, 8'hA0}, {1'b0, 8'hA6},
        {1'b0, 8'hB8}, {1'b0, 8'h28}, {1'b0, 8'hEA}, {1'b1, 8'hAA}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1, wr_busy = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_oe, req_valid, req_ack;
    logic [1:0] req_kind;
    logic [AW-1:0] req_addr;
    logic [7:0] req_wdata, rd_data;
    logic sda_line;

    int n_chk = 0, n_fail = 0, viol = 0, log_n = 0;
    logic [7:0] mem [1024];
    logic [1:0] log_kind [64];
    logic [AW-1:0] log_addr [64];
    logic [7:0] log_data [64];
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    tws_slave dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .wr_busy(wr_busy), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .rd_data(rd_data)
    );

    initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;

    always @(posedge clk) begin
        if (rst) begin
            req_ack <= 1'b0;
            rd_data <= '0;
        end else begin
            req_ack <= req_valid && !req_ack;
            if (req_valid && !req_ack) begin
                log_kind[log_n] <= req_kind;
                log_addr[log_n] <= req_addr;
                if (req_kind == 2'd1) begin
                    mem[req_addr] <= req_wdata;
                    log_data[log_n] <= req_wdata;
                end else begin
                    rd_data <= mem[req_addr];
                    log_data[log_n] <= mem[req_addr];
                end
                log_n <= log_n + 1;
            end
        end
    end

    // R11 monitor: pull-low enable must not move while the master clock is high
    always @(negedge clk) begin
        if (!rst && sda_oe != prev_oe && m_scl) viol++;
        prev_oe <= sda_oe;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(HOLD);
    endtask

    task automatic bus_stop();
        if (m_scl) begin m_scl = 1'b0; wt(HOLD); end
        m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        if (m_scl) begin m_scl = 1'b0; wt(HOLD); end
        for (int i = 0; i < n; i++) begin
            m_sda = b[7-i]; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(HOLD);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q/2);
        ack = ~sda_line;
        wt(Q/2); m_scl = 1'b0; wt(HOLD);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q); m_scl = 1'b1; wt(Q/2); b[i] = sda_line; wt(Q/2); m_scl = 1'b0; wt(HOLD);
        end
        m_sda = mack ? 1'b0 : 1'b1;
        wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(HOLD); m_sda = 1'b1;
    endtask

    initial begin
        wt(150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        int base;
        wt(5); rst = 1'b0; wt(3);

        // R12 reset state
        check("R12 oe", 32'(sda_oe), 0);
        check("R12 req_valid", 32'(req_valid), 0);
        base = log_n;
        bus_start(); send_byte(8'hA9, a); check("R2 read select ack", 32'(a), 1);
        recv_byte(1'b0, d); bus_stop(); wt(4);
        check("R12 address 0 data", 32'(d), 32'h5A);
        check("R12 read addr", 32'(log_addr[base]), 0);

        // R2/R3 select decoding table
        foreach (VEC[k]) begin
            bus_start(); send_byte(VEC[k][7:0], a); bus_stop();
            check($sformatf("R2 R3 select %h", VEC[k][7:0]), 32'(a), 32'(VEC[k][8]));
        end

        // R4/R5 page write with page bits 2'b10 and in-page wrap
        base = log_n;
        bus_start(); send_byte(8'hAC, a); check("R2 write select", 32'(a), 1);
        send_byte(8'h3C, a); check("R4 waddr ack", 32'(a), 1);
        for (int i = 0; i < 5; i++) begin
            send_byte(8'hA1 + 8'(i), a); check("R4 data ack", 32'(a), 1);
        end
        bus_stop(); wt(4);
        check("R4 req count", 32'(log_n - base), 6);
        check("R4 load kind", 32'(log_kind[base]), 0);
        check("R3 load addr", 32'(log_addr[base]), 32'h23C);
        for (int i = 0; i < 5; i++) begin
            check("R4 write kind", 32'(log_kind[base+1+i]), 1);
            check("R5 write addr", 32'(log_addr[base+1+i]), 32'h230 | ((32'hC + 32'(i)) & 32'hF));
            check("R4 write data", 32'(log_data[base+1+i]), 32'hA1 + 32'(i));
        end

        // R8 random read, R6 full increment across page, R7 stop on NACK
        base = log_n;
        bus_start(); send_byte(8'hAC, a); send_byte(8'h3E, a);
        bus_start(); send_byte(8'hA9, a); check("R8 read select ack", 32'(a), 1);
        recv_byte(1'b1, d); check("R8 first byte", 32'(d), 32'hA3);
        recv_byte(1'b1, d); check("R7 next after ack", 32'(d), 32'hA4);
        recv_byte(1'b0, d); check("R6 cross page", 32'(d), 32'h1A);
        bus_stop(); wt(4);
        check("R7 no read after nack", 32'(log_n - base), 4);
        check("R6 third read addr", 32'(log_addr[base+3]), 32'h240);

        // R6 current address read
        bus_start(); send_byte(8'hA9, a); recv_byte(1'b0, d); bus_stop();
        check("R6 current address", 32'(d), 32'h1B);

        // R6 wrap from top of space to 0
        bus_start(); send_byte(8'hAE, a); send_byte(8'hFF, a);
        bus_start(); send_byte(8'hA9, a);
        recv_byte(1'b1, d); check("R6 top byte", 32'(d), 32'hA5);
        recv_byte(1'b0, d); check("R6 wrap to 0", 32'(d), 32'h5A);
        bus_stop();

        // R9 busy
        wr_busy = 1'b1; base = log_n;
        bus_start(); send_byte(8'hA8, a); bus_stop(); wt(4);
        check("R9 busy nack", 32'(a), 0);
        check("R9 busy no req", 32'(log_n - base), 0);
        wr_busy = 1'b0;

        // R10 stop inside a data byte
        base = log_n;
        bus_start(); send_byte(8'hA8, a); send_byte(8'h10, a);
        send_bits(8'hF0, 4); bus_stop(); wt(4);
        check("R10 only load issued", 32'(log_n - base), 1);
        bus_start(); send_byte(8'hA9, a); recv_byte(1'b0, d); bus_stop();
        check("R10 memory unchanged", 32'(d), 32'h4A);

        // R10 start inside a byte
        bus_start(); send_bits(8'hA8, 3); bus_start();
        send_byte(8'hA8, a); bus_stop();
        check("R10 restart select ack", 32'(a), 1);

        // R1 bytes after stop without start ignored
        send_byte(8'hA8, a); check("R1 idle after stop", 32'(a), 0);

        // R2 bus ignored after mismatch
        base = log_n;
        bus_start(); send_byte(8'hA0, a); check("R2 mismatch nack", 32'(a), 0);
        send_byte(8'hA8, a); check("R2 ignored after mismatch", 32'(a), 0);
        bus_stop(); wt(4);
        check("R2 no req after mismatch", 32'(log_n - base), 0);

        check("R11 oe moved with clock high", 32'(viol), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule